// File: doc/BRIEF.md
# I2C Master Command Trigger Engine

This block is an I2C master bus engine that performs one primitive bus operation per software trigger. The host writes an 8-bit control register holding a 3-bit operation code and a trigger bit. The engine then drives the clock and data lines through open-drain style pull-low enables until that single operation is done, and clears the trigger bit to report completion. Operations are: start condition, stop condition, send a byte, receive a byte, send ACK, send NAK and receive ACK/NAK. A full transfer is built by software as a chain of these primitives. The engine has no transaction-level state machine.

The outgoing byte is captured when a trigger is accepted. The received byte and the received acknowledge bit are held until the next receive of the same kind. One operation runs at a time, and the trigger bit serves as the only handshake, so the data paths have no back-pressure. A write that arrives while an operation runs is dropped. Each clock-line phase lasts `phase_div + 1` system clocks, and `phase_div` must be held steady during an operation. The sampled data input is assumed to be already synchronised to `clk`. Clock stretching and arbitration are not handled.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, both `scl_oe` and `sda_oe` are 0 (lines released), and `rx_byte` and `ack_nak` are 0.
- R2: `reg_rdata` bits [2:0] return the last accepted operation code. Bit 4 is the busy/trigger flag. Bits 7..5 and bit 3 always read 0. An idle write updates the code whether or not the master mode input is set.
- R3: An idle write with bit 4 = 1 starts the operation coded in bits [2:0] only when `master_en` is 1. With bit 4 = 0, or with `master_en` = 0, no operation starts and the lines do not move.
- R4: The trigger flag reads 1 for exactly 1 + N·(phase_div+1) cycles after the accepting write edge. N is 4 for a start, 3 for a stop, 24 for a byte transfer and 3 for any single-bit operation. It then returns to 0.
- R5: Any register write made while the trigger flag is 1 is ignored: the code and the running operation are not changed.
- R6: Code 7 is reserved. A trigger with code 7 leaves the flag at 0 and causes no line activity.
- R7: Code 0 (start): SDA goes from released to driven low while SCL is released. The operation ends with both lines driven low.
- R8: Code 1 (stop): SDA goes from driven low to released while SCL is released. The operation ends with both lines released.
- R9: Code 2 (send byte): eight SCL high pulses carry the captured byte MSB first. SDA changes only while SCL is driven low.
- R10: Code 3 (receive byte): SDA is released. The line is sampled at the end of each of eight SCL high phases, MSB first, and the byte appears on `rx_byte` when the operation completes.
- R11: Code 4 drives SDA low for one SCL high pulse (ACK). Code 5 leaves SDA released for one pulse (NAK).
- R12: Code 6 releases SDA for one SCL pulse, samples it, and sets `ack_nak` to the sampled level (1 = NAK).
- R13: `scl_oe` and `sda_oe` change only at phase boundaries, and every phase is `phase_div + 1` system clocks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Interface configured as I2C master; triggers are ignored when low |
| phase_div | input | DIV_W | SCL phase length minus one, in system clocks |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| tx_byte | input | DATA_W | Byte to send, captured on an accepted trigger |
| rx_byte | output | DATA_W | Last received byte |
| ack_nak | output | 1 | Last sampled acknowledge level (1 = NAK) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench sweeps every byte value through both send and receive at the shortest phase length, and a set of edge patterns at longer phases. Bit-order slips or a shift register that loses its end bit would show up there as a wrong byte. Busy time is counted cycle by cycle against 1 + N·(phase_div+1), so an extra or missing phase, or a divider off by one, gives a miscount. A line monitor counts SDA edges while SCL is released: a byte op that moves data during the high phase, or a start or stop with the wrong edge direction, is caught. The bench also writes during a busy operation, triggers the reserved code, and triggers with master mode off. These catch a design that lets a late write change the code, or that starts bus activity when it should not.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_STOP  = 3'd1,
    OP_TXD   = 3'd2,
    OP_RXD   = 3'd3,
    OP_TXACK = 3'd4,
    OP_TXNAK = 3'd5,
    OP_RXACK = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  localparam int TRIG_BIT = 4;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } drive_t;

  // Line drive for a given operation and phase index within a bit slot.
  function automatic drive_t phase_drive(op_e op, logic [1:0] sub, logic dbit);
    drive_t d;
    d.scl_low = (sub != 2'd1);
    d.sda_low = 1'b0;
    case (op)
      OP_START: begin
        d.scl_low = (sub == 2'd0) || (sub == 2'd3);
        d.sda_low = (sub >= 2'd2);
      end
      OP_STOP: begin
        d.scl_low = (sub == 2'd0);
        d.sda_low = (sub != 2'd2);
      end
      OP_TXD:   d.sda_low = !dbit;
      OP_TXACK: d.sda_low = 1'b1;
      default:  d.sda_low = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic [1:0] final_sub(op_e op);
    return (op == OP_START) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic is_byte_op(op_e op);
    return (op == OP_TXD) || (op == OP_RXD);
  endfunction

  function automatic logic is_slot_op(op_e op);
    return (op != OP_START) && (op != OP_STOP);
  endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/i2c_trig_regs.sv
module i2c_trig_regs
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              op_done,
  output logic [7:0]        reg_rdata,
  output logic              launch,
  output op_e               op_mode,
  output logic [DATA_W-1:0] tx_hold
);

  logic trig_q;
  logic launch_q;
  op_e  mode_q;
  logic [DATA_W-1:0] tx_q;

  logic accept, fire;
  op_e  wr_op;
  wire  unused_wbits = ^{reg_wdata[7:5], reg_wdata[3]};

  assign wr_op  = op_e'(reg_wdata[2:0]);
  assign accept = reg_wr && !trig_q;
  assign fire   = accept && reg_wdata[TRIG_BIT] && master_en && (wr_op != OP_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q   <= 1'b0;
      launch_q <= 1'b0;
      mode_q   <= OP_START;
      tx_q     <= '0;
    end else begin
      launch_q <= 1'b0;
      if (accept) mode_q <= wr_op;
      if (fire) begin
        trig_q   <= 1'b1;
        launch_q <= 1'b1;
        tx_q     <= tx_byte;
      end else if (op_done) begin
        trig_q <= 1'b0;
      end
    end
  end

  assign reg_rdata = {3'b000, trig_q, 1'b0, mode_q};
  assign launch    = launch_q;
  assign op_mode   = mode_q;
  assign tx_hold   = tx_q;

  a_r6_rsvd_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !trig_q && reg_wdata[2:0] == 3'd7) |=> !trig_q);

  a_r3_disabled_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !trig_q && !master_en) |=> !trig_q);

  a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !op_done) |=> ($stable(mode_q) && trig_q));

endmodule

// File: rtl/i2c_bit_seq.sv
module i2c_bit_seq
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  op_e               op_in,
  input  logic [DATA_W-1:0] tx_hold,
  input  logic              tick,
  input  logic              sda_in,
  output logic              run,
  output logic              op_done,
  output logic              scl_low,
  output logic              sda_low,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_nak
);

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              run_q;
  op_e               op_q;
  logic [1:0]        sub_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] rx_sh_q;
  logic [DATA_W-1:0] rx_q;
  logic              ack_q;
  drive_t            drv_q;

  logic is_last, wrap;

  assign is_last = (sub_q == final_sub(op_q)) &&
                   (!is_byte_op(op_q) || (bit_q == LAST_BIT));
  assign wrap    = (sub_q == 2'd2) && is_slot_op(op_q);
  assign op_done = tick && is_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      op_q    <= OP_START;
      sub_q   <= 2'd0;
      bit_q   <= '0;
      shift_q <= '0;
      rx_sh_q <= '0;
      rx_q    <= '0;
      ack_q   <= 1'b0;
      drv_q   <= '0;
    end else if (launch && !run_q) begin
      run_q   <= 1'b1;
      op_q    <= op_in;
      sub_q   <= 2'd0;
      bit_q   <= '0;
      shift_q <= tx_hold;
      drv_q   <= phase_drive(op_in, 2'd0, tx_hold[DATA_W-1]);
    end else if (tick) begin
      if (sub_q == 2'd1) begin
        if (op_q == OP_RXD)   rx_sh_q <= {rx_sh_q[DATA_W-2:0], sda_in};
        if (op_q == OP_RXACK) ack_q   <= sda_in;
      end
      if (is_last) begin
        run_q <= 1'b0;
        if (op_q == OP_RXD) rx_q <= rx_sh_q;
      end else if (wrap) begin
        sub_q   <= 2'd0;
        bit_q   <= bit_q + 1'b1;
        shift_q <= {shift_q[DATA_W-2:0], 1'b0};
        drv_q   <= phase_drive(op_q, 2'd0, shift_q[DATA_W-2]);
      end else begin
        sub_q <= sub_q + 2'd1;
        drv_q <= phase_drive(op_q, sub_q + 2'd1, shift_q[DATA_W-1]);
      end
    end
  end

  assign run     = run_q;
  assign scl_low = drv_q.scl_low;
  assign sda_low = drv_q.sda_low;
  assign rx_byte = rx_q;
  assign ack_nak = ack_q;

  a_r9_sda_still_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && is_slot_op(op_q) && !scl_low && $past(!scl_low)) |-> $stable(sda_low));

  a_r13_moves_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({scl_low, sda_low}) |-> $past(tick || launch));

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic [DIV_W-1:0]  phase_div,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_nak,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);

  logic              launch, op_done, run, tick;
  op_e               op_mode;
  logic [DATA_W-1:0] tx_hold;

  i2c_trig_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_en (master_en),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .tx_byte   (tx_byte),
    .op_done   (op_done),
    .reg_rdata (reg_rdata),
    .launch    (launch),
    .op_mode   (op_mode),
    .tx_hold   (tx_hold)
  );

  i2c_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .div   (phase_div),
    .tick  (tick)
  );

  i2c_bit_seq #(.DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .op_in   (op_mode),
    .tx_hold (tx_hold),
    .tick    (tick),
    .sda_in  (sda_in),
    .run     (run),
    .op_done (op_done),
    .scl_low (scl_oe),
    .sda_low (sda_oe),
    .rx_byte (rx_byte),
    .ack_nak (ack_nak)
  );

endmodule

// File: tb/sim_i2c_cmd_engine.sv
`timescale 1ns/1ps
module sim_i2c_cmd_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_en = 1'b0;
  logic [7:0] phase_div = 8'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [7:0] tx_byte = 8'd0;
  logic [7:0] rx_byte;
  logic       ack_nak;
  logic       sda_in;
  logic       scl_oe, sda_oe;

  int vectors = 0;
  int miscompares = 0;

  // bus model state, written only by the monitor below
  int   rises = 0, falls = 0, hi_rise = 0, hi_fall = 0;
  logic [7:0] got = 8'd0;
  logic prev_scl_low = 1'b0, prev_sda = 1'b1;
  // slave stimulus, written only by the initial block
  logic       slave_en = 1'b0;
  logic [7:0] slave_byte = 8'hFF;
  int         slave_base = 0;
  logic       slave_pull;

  always #2 clk = ~clk;

  always_comb begin
    int idx;
    idx = falls - slave_base;
    slave_pull = slave_en && (idx >= 0) && (idx < 8) && !slave_byte[7 - idx];
  end
  assign sda_in = !(sda_oe || slave_pull);

  i2c_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .phase_div(phase_div),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .ack_nak(ack_nak),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    logic line;
    line = sda_in;
    if (prev_scl_low && !scl_oe) begin rises++; got = {got[6:0], line}; end
    if (!prev_scl_low && scl_oe) falls++;
    if (!prev_scl_low && !scl_oe && prev_sda != line) begin
      if (line) hi_rise++; else hi_fall++;
    end
    prev_scl_low = scl_oe;
    prev_sda = line;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Runs one operation and checks busy length and line behaviour.
  task automatic run_op(input logic [2:0] m, input logic [7:0] tx, input int nph, input bit poke);
    int busy, r0, hr0, hf0;
    @(negedge clk);
    r0 = rises; hr0 = hi_rise; hf0 = hi_fall;
    slave_base = falls;
    tx_byte = tx;
    reg_wr = 1'b1; reg_wdata = {3'b000, 1'b1, 1'b0, m};
    busy = 0;
    @(negedge clk);
    reg_wr = 1'b0;
    while (reg_rdata[4] && busy < 5000) begin
      busy++;
      if (poke && busy == 2) begin reg_wr = 1'b1; reg_wdata = 8'h13; end
      else if (poke && busy == 3) begin
        reg_wr = 1'b0;
        chk("R5 mode kept during busy write", {29'd0, reg_rdata[2:0]}, {29'd0, m});
      end
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk("R4/R13 busy cycles", busy, 1 + nph * (phase_div + 1));
    case (m)
      3'd0: begin
        chk("R7 sda fall while scl high", hi_fall - hf0, 1);
        chk("R7 no sda rise while scl high", hi_rise - hr0, 0);
        chk("R7 end state", {scl_oe, sda_oe}, 2'b11);
      end
      3'd1: begin
        chk("R8 sda rise while scl high", hi_rise - hr0, 1);
        chk("R8 no sda fall while scl high", hi_fall - hf0, 0);
        chk("R8 end state", {scl_oe, sda_oe}, 2'b00);
      end
      3'd2: begin
        chk("R9 pulses", rises - r0, 8);
        chk("R9 byte msb first", got, tx);
        chk("R9 sda quiet while scl high", (hi_rise - hr0) + (hi_fall - hf0), 0);
      end
      3'd3: begin
        chk("R10 pulses", rises - r0, 8);
        chk("R10 rx byte", rx_byte, slave_byte);
        chk("R10 sda quiet while scl high", (hi_rise - hr0) + (hi_fall - hf0), 0);
      end
      3'd4: begin
        chk("R11 ack pulses", rises - r0, 1);
        chk("R11 ack level", got[0], 1'b0);
      end
      3'd5: begin
        chk("R11 nak pulses", rises - r0, 1);
        chk("R11 nak level", got[0], 1'b1);
      end
      default: begin
        chk("R12 pulses", rises - r0, 1);
        chk("R12 ack status", ack_nak, slave_byte[7]);
      end
    endcase
  endtask

  task automatic idle_quiet(input string req, input int n);
    int r0, f0;
    logic [1:0] lines;
    r0 = rises; f0 = falls; lines = {scl_oe, sda_oe};
    repeat (n) @(negedge clk);
    chk(req, {rises - r0, falls - f0}, 64'd0);
    chk(req, {30'd0, scl_oe, sda_oe}, {30'd0, lines});
    chk(req, {31'd0, reg_rdata[4]}, 32'd0);
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 8'h00);
    chk("R1 reset lines", {scl_oe, sda_oe}, 2'b00);
    chk("R1 reset rx", {rx_byte, ack_nak}, 9'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: mode field r/w, reserved bits read 0, master disabled
    reg_write(8'hFF);
    chk("R2 reserved zero, mode r/w", reg_rdata, 8'h07);
    reg_write(8'h12);
    chk("R2 mode updated while disabled", reg_rdata, 8'h02);
    // R3: trigger ignored when not master
    idle_quiet("R3 disabled trigger no activity", 20);

    master_en = 1'b1;
    reg_write(8'h01);
    chk("R3 write 0 to trigger ignored", reg_rdata, 8'h01);
    idle_quiet("R3 zero trigger no activity", 10);
    reg_write(8'h17);
    chk("R6 reserved code flag", reg_rdata, 8'h07);
    idle_quiet("R6 reserved code no activity", 20);

    for (int d = 0; d < 3; d++) begin
      phase_div = (d == 0) ? 8'd0 : (d == 1) ? 8'd1 : 8'd3;
      run_op(3'd0, 8'h00, 4, 1'b0);
      for (int b = 0; b < 256; b++) begin
        if (d == 0 || b == 0 || b == 255 || b == 8'hA5 || b == 8'h5A || b == 1 || b == 8'h80)
          run_op(3'd2, 8'(b), 24, 1'b0);
      end
      run_op(3'd2, 8'hA5, 24, 1'b1);
      run_op(3'd4, 8'h00, 3, 1'b0);
      run_op(3'd5, 8'h00, 3, 1'b0);
      slave_en = 1'b1;
      for (int b = 0; b < 256; b++) begin
        if (d == 0 || b == 0 || b == 255 || b == 8'h3C || b == 8'hC3 || b == 1 || b == 8'h80) begin
          slave_byte = 8'(b);
          run_op(3'd3, 8'h00, 24, 1'b0);
        end
      end
      slave_byte = 8'h7F;
      run_op(3'd6, 8'h00, 3, 1'b0);
      slave_byte = 8'hFF;
      run_op(3'd6, 8'h00, 3, 1'b0);
      slave_en = 1'b0;
      run_op(3'd0, 8'h00, 4, 1'b0);
      run_op(3'd1, 8'h00, 3, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule